// File: doc/BRIEF.md
# Word-to-Byte Memory Cycle Splitter

This block sits between a 16-bit processor's bus interface and a memory bus that may carry either word-wide or byte-wide slaves. At the start of each bus cycle it compares the processor's 16-bit transfer request with the slave's 16-bit acknowledge. If a word was requested and the acknowledge is absent, the block turns the one word access into two byte accesses. The even byte is accessed first and the odd byte second. The block drives the bus address bit 0 through that sequence and requests wait states, so the processor sees one lengthened cycle.

On a read, the even byte is held in a latch while the odd byte is fetched. The two bytes are then presented together as one word on the processor's read data. On a write, the byte lane carries the low half of the processor's word during the even phase and the high half during the odd phase. A strap input forces word-only operation, which disables the splitter. Data moves through the block only while both the bus controller's data enable and the interrupt controller's enable are high.

Top module: `word_byte_splitter`

## Requirements
- R1: A split begins when `cyc_start` is sampled high with `word_req`=1, `word_ack`=0 and `force_word`=0.
- R2: During a split, `bus_a0` is 0 for the first 3 clock periods after the starting edge. It is then 1 for the next 3 periods and stays 1 until the cycle ends.
- R3: `wait_req` is 1 for exactly the 6 clock periods of the two byte phases, starting in the first period after the starting edge. It is 0 afterwards.
- R4: On a split read (`is_read`=1), the byte on `bus_di[7:0]` is captured on the edge where `bus_a0` rises. From then on, `cpu_di` = {`bus_di[7:0]`, captured byte}.
- R5: On a split write, `bus_do[7:0]` carries `cpu_do[7:0]` while `bus_a0`=0 and `cpu_do[15:8]` while `bus_a0`=1.
- R6: With `force_word`=1, a missing acknowledge starts no split: `wait_req` stays 0 and `bus_a0` follows `cpu_a0`.
- R7: Whenever `data_en`=0 or `ictl_en`=0, both `cpu_di` and `bus_do` are 0.
- R8: Outside a split, `bus_a0` equals `cpu_a0` one clock later, `wait_req` is 0, `cpu_di` equals `bus_di` and `bus_do` equals `cpu_do`.
- R9: A `cyc_start` pulse during a split has no effect on the sequence. After the wait is released, the block returns to pass-through on the first edge where `cyc_end` is high.
- R10: A synchronous `rst` returns the block to idle, with `bus_a0`=0 and `wait_req`=0, even in the middle of a split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock pulse marking the start of a bus cycle |
| cyc_end | input | 1 | High in the clock where the bus cycle finishes |
| word_req | input | 1 | Processor requests a 16-bit transfer |
| word_ack | input | 1 | Slave acknowledges it can do a 16-bit transfer |
| force_word | input | 1 | Strap: word-only operation, splitter disabled |
| is_read | input | 1 | Current cycle is a read |
| cpu_a0 | input | 1 | Processor address bit 0 |
| data_en | input | 1 | Data enable from the bus controller |
| ictl_en | input | 1 | Enable from the interrupt controller |
| cpu_do | input | 16 | Processor write data |
| bus_di | input | 16 | Read data from the bus |
| bus_a0 | output | 1 | Address bit 0 driven to the bus |
| wait_req | output | 1 | Wait-state request to the processor |
| cpu_di | output | 16 | Read data to the processor |
| bus_do | output | 16 | Write data to the bus |

## Verification
The bench counts the periods of `bus_a0` low and high, and of `wait_req`, against a byte-wide slave. A design with an off-by-one in either phase would move the A0 edge or shorten the wait, and the slave would see a byte for too short a time. The assembled read word is compared with the slave's two bytes. A latch that captured one edge late would pick up the odd byte twice. A write split must store the two halves at the right byte addresses, since swapped lanes would exchange them. Further cases cover a second start pulse arriving mid-split, reset in the middle of a split, the word-only strap, and the enable gating. Each of these would show as stray wait states, a restarted sequence, or data leaking through while disabled.

// File: rtl/split_pkg.sv
package split_pkg;
  typedef enum logic [1:0] {
    SP_IDLE = 2'd0,
    SP_LOW  = 2'd1,
    SP_HIGH = 2'd2,
    SP_DONE = 2'd3
  } sp_state_t;
endpackage

// File: rtl/split_seq.sv
module split_seq
  import split_pkg::*;
#(
  parameter int PHASE_CYC = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      cyc_start,
  input  logic      cyc_end,
  input  logic      word_req,
  input  logic      word_ack,
  input  logic      force_word,
  input  logic      cpu_a0,
  output logic      a0_q,
  output logic      wait_q,
  output sp_state_t state,
  output logic      even_strobe
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYC - 1);

  sp_state_t      nxt;
  logic [CW-1:0]  cnt;
  logic           start_split;

  assign start_split = cyc_start && word_req && !word_ack && !force_word;
  assign even_strobe = (state == SP_LOW) && (cnt == LAST);

  always_comb begin
    nxt = state;
    case (state)
      SP_IDLE: if (start_split) nxt = SP_LOW;
      SP_LOW:  if (cnt == LAST) nxt = SP_HIGH;
      SP_HIGH: if (cnt == LAST) nxt = SP_DONE;
      SP_DONE: if (cyc_end) nxt = SP_IDLE;
      default: nxt = SP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SP_IDLE;
      cnt    <= '0;
      a0_q   <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= '0;
      else if (state == SP_LOW || state == SP_HIGH) cnt <= cnt + 1'b1;
      case (nxt)
        SP_LOW:           a0_q <= 1'b0;
        SP_HIGH, SP_DONE: a0_q <= 1'b1;
        default:          a0_q <= cpu_a0;
      endcase
      wait_q <= (nxt == SP_LOW) || (nxt == SP_HIGH);
    end
  end

  // R1: a qualifying start enters the even phase with wait raised
  a_r1_split_start: assert property (@(posedge clk) disable iff (rst)
    (state == SP_IDLE && cyc_start && word_req && !word_ack && !force_word)
      |=> (wait_q && !a0_q));
  // R6: strap suppresses any split
  a_r6_forced_word: assert property (@(posedge clk) disable iff (rst)
    (state == SP_IDLE && force_word) |=> !wait_q);
  // R2: A0 rises exactly when the even phase completes
  a_r2_a0_rise: assert property (@(posedge clk) disable iff (rst)
    even_strobe |=> (a0_q && wait_q));
  // R3: wait drops when leaving the odd phase
  a_r3_wait_release: assert property (@(posedge clk) disable iff (rst)
    (state == SP_HIGH && cnt == LAST) |=> (!wait_q && a0_q));
  // R9: no return to idle before the cycle end is seen
  a_r9_hold_until_end: assert property (@(posedge clk) disable iff (rst)
    (state == SP_DONE && !cyc_end) |=> (state == SP_DONE));
endmodule

// File: rtl/even_latch.sv
module even_latch #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (capture) q <= din;
  end
endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int DATA_W = 16
) (
  input  logic              xfer_en,
  input  logic              split_act,
  input  logic              odd_phase,
  input  logic              rd_assemble,
  input  logic [DATA_W/2-1:0] even_byte,
  input  logic [DATA_W-1:0] cpu_do,
  input  logic [DATA_W-1:0] bus_di,
  output logic [DATA_W-1:0] cpu_di,
  output logic [DATA_W-1:0] bus_do
);
  localparam int BW = DATA_W / 2;

  always_comb begin
    cpu_di = '0;
    bus_do = '0;
    if (xfer_en) begin
      if (rd_assemble) cpu_di = {bus_di[BW-1:0], even_byte};
      else             cpu_di = bus_di;
      if (split_act)
        bus_do = {{BW{1'b0}}, (odd_phase ? cpu_do[DATA_W-1:BW] : cpu_do[BW-1:0])};
      else
        bus_do = cpu_do;
    end
  end
endmodule

// File: rtl/word_byte_splitter.sv
module word_byte_splitter
  import split_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int PHASE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_start,
  input  logic              cyc_end,
  input  logic              word_req,
  input  logic              word_ack,
  input  logic              force_word,
  input  logic              is_read,
  input  logic              cpu_a0,
  input  logic              data_en,
  input  logic              ictl_en,
  input  logic [DATA_W-1:0] cpu_do,
  input  logic [DATA_W-1:0] bus_di,
  output logic              bus_a0,
  output logic              wait_req,
  output logic [DATA_W-1:0] cpu_di,
  output logic [DATA_W-1:0] bus_do
);
  localparam int BW = DATA_W / 2;

  sp_state_t       st;
  logic            strobe;
  logic [BW-1:0]   even_q;
  logic            split_act;
  logic            odd_phase;

  split_seq #(.PHASE_CYC(PHASE_CYC)) i_seq (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .word_req(word_req), .word_ack(word_ack), .force_word(force_word),
    .cpu_a0(cpu_a0), .a0_q(bus_a0), .wait_q(wait_req), .state(st),
    .even_strobe(strobe)
  );

  even_latch #(.BYTE_W(BW)) i_latch (
    .clk(clk), .rst(rst), .capture(strobe && is_read),
    .din(bus_di[BW-1:0]), .q(even_q)
  );

  assign split_act = (st != SP_IDLE);
  assign odd_phase = (st == SP_HIGH) || (st == SP_DONE);

  lane_steer #(.DATA_W(DATA_W)) i_steer (
    .xfer_en(data_en && ictl_en), .split_act(split_act), .odd_phase(odd_phase),
    .rd_assemble(odd_phase && is_read), .even_byte(even_q),
    .cpu_do(cpu_do), .bus_di(bus_di), .cpu_di(cpu_di), .bus_do(bus_do)
  );

  // R7: nothing crosses the data path while either enable is low
  a_r7_gated: assert property (@(posedge clk) disable iff (rst)
    !(data_en && ictl_en) |-> (cpu_di == '0 && bus_do == '0));
  // R8: an acknowledged word cycle raises no wait
  a_r8_ack_no_wait: assert property (@(posedge clk) disable iff (rst)
    (!split_act && cyc_start && word_ack) |=> !wait_req);
  // R5: split write lanes follow the A0 phase
  a_r5_write_lane: assert property (@(posedge clk) disable iff (rst)
    (split_act && !is_read && data_en && ictl_en && !bus_a0)
      |-> (bus_do[BW-1:0] == cpu_do[BW-1:0]));
endmodule

// File: tb/test_word_byte_splitter.sv
module test_word_byte_splitter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 0, cyc_end = 0, word_req = 0, word_ack = 0, force_word = 0;
  logic is_read = 0, cpu_a0 = 0, data_en = 1, ictl_en = 1;
  logic [15:0] cpu_do = '0;
  logic [15:0] bus_di;
  logic bus_a0, wait_req;
  logic [15:0] cpu_di, bus_do;

  logic [7:0]  mem8 [2];
  logic [15:0] word16 = 16'hBEEF;
  logic        sel16 = 0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    if (sel16) bus_di = word16;
    else       bus_di = {8'h00, mem8[bus_a0]};
  end

  word_byte_splitter i_word_byte_splitter (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_end(cyc_end),
    .word_req(word_req), .word_ack(word_ack), .force_word(force_word),
    .is_read(is_read), .cpu_a0(cpu_a0), .data_en(data_en), .ictl_en(ictl_en),
    .cpu_do(cpu_do), .bus_di(bus_di), .bus_a0(bus_a0), .wait_req(wait_req),
    .cpu_di(cpu_di), .bus_do(bus_do)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic rd, input logic ack);
    @(negedge clk);
    is_read = rd; word_req = 1; word_ack = ack; sel16 = ack; cyc_start = 1;
    @(negedge clk);
    cyc_start = 0;
  endtask

  task automatic end_cycle();
    cyc_end = 1;
    @(negedge clk);
    cyc_end = 0; word_req = 0; word_ack = 0;
    @(negedge clk);
  endtask

  // Walk the 7 periods after the starting edge; k=1 is the current one
  task automatic walk_split(input bit rd, input bit extra_start, output int lows, output int highs, output int waits);
    lows = 0; highs = 0; waits = 0;
    for (int k = 1; k <= 7; k++) begin
      if (wait_req) waits++;
      if (wait_req && !bus_a0) lows++;
      if (wait_req && bus_a0) highs++;
      if (k <= 3) chk(bus_a0 == 1'b0, "R2 a0 low phase", {15'd0, bus_a0}, 16'd0);
      else        chk(bus_a0 == 1'b1, "R2 a0 high phase", {15'd0, bus_a0}, 16'd1);
      if (!rd) mem8[bus_a0] = bus_do[7:0];
      if (extra_start && k == 2) cyc_start = 1;
      @(negedge clk);
      cyc_start = 0;
    end
  endtask

  task automatic t_reset();
    chk(bus_a0 == 1'b0, "R10 reset a0", {15'd0, bus_a0}, 16'd0);
    chk(wait_req == 1'b0, "R10 reset wait", {15'd0, wait_req}, 16'd0);
  endtask

  task automatic t_word_pass();
    pulse_start(1'b1, 1'b1);
    chk(wait_req == 1'b0, "R8 no wait on ack", {15'd0, wait_req}, 16'd0);
    chk(cpu_di == 16'hBEEF, "R8 word read", cpu_di, 16'hBEEF);
    cpu_a0 = 1; cpu_do = 16'h1234;
    @(negedge clk);
    chk(bus_a0 == 1'b1, "R8 a0 follows", {15'd0, bus_a0}, 16'd1);
    chk(bus_do == 16'h1234, "R8 write pass", bus_do, 16'h1234);
    cpu_a0 = 0;
    end_cycle();
  endtask

  task automatic t_split_read(input bit extra);
    int l, h, w;
    mem8[0] = 8'h5A; mem8[1] = 8'hC3;
    pulse_start(1'b1, 1'b0);
    walk_split(1'b1, extra, l, h, w);
    chk(l == 3, extra ? "R9 low len with extra start" : "R2 low len", 16'(l), 16'd3);
    chk(w == 6, extra ? "R9 wait len with extra start" : "R3 wait len", 16'(w), 16'd6);
    chk(wait_req == 1'b0, "R3 wait released", {15'd0, wait_req}, 16'd0);
    chk(cpu_di == 16'hC35A, "R4 assembled word", cpu_di, 16'hC35A);
    @(negedge clk);
    chk(bus_a0 == 1'b1, "R2 a0 held until end", {15'd0, bus_a0}, 16'd1);
    end_cycle();
    chk(bus_a0 == cpu_a0, "R9 back to pass-through", {15'd0, bus_a0}, {15'd0, cpu_a0});
  endtask

  task automatic t_split_write();
    int l, h, w;
    mem8[0] = 8'h00; mem8[1] = 8'h00;
    cpu_do = 16'hA7E1;
    pulse_start(1'b0, 1'b0);
    walk_split(1'b0, 1'b0, l, h, w);
    chk(mem8[0] == 8'hE1, "R5 even byte written", {8'h00, mem8[0]}, 16'h00E1);
    chk(mem8[1] == 8'hA7, "R5 odd byte written", {8'h00, mem8[1]}, 16'h00A7);
    chk(h == 3, "R2 high len", 16'(h), 16'd3);
    end_cycle();
  endtask

  task automatic t_forced();
    force_word = 1;
    pulse_start(1'b1, 1'b0);
    for (int k = 0; k < 4; k++) begin
      chk(wait_req == 1'b0, "R6 no wait when forced", {15'd0, wait_req}, 16'd0);
      @(negedge clk);
    end
    chk(bus_a0 == cpu_a0, "R6 a0 follows when forced", {15'd0, bus_a0}, {15'd0, cpu_a0});
    end_cycle();
    force_word = 0;
  endtask

  task automatic t_gate();
    sel16 = 1; cpu_do = 16'hFFFF;
    data_en = 0;
    #1;
    chk(cpu_di == 16'h0000, "R7 data_en low read", cpu_di, 16'h0000);
    chk(bus_do == 16'h0000, "R7 data_en low write", bus_do, 16'h0000);
    data_en = 1; ictl_en = 0;
    #1;
    chk(cpu_di == 16'h0000, "R7 ictl_en low read", cpu_di, 16'h0000);
    ictl_en = 1;
    #1;
    chk(cpu_di == 16'hBEEF, "R7 enabled read", cpu_di, 16'hBEEF);
    sel16 = 0;
    @(negedge clk);
  endtask

  task automatic t_reset_mid();
    pulse_start(1'b1, 1'b0);
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(wait_req == 1'b0, "R10 reset mid-split wait", {15'd0, wait_req}, 16'd0);
    chk(bus_a0 == 1'b0, "R10 reset mid-split a0", {15'd0, bus_a0}, 16'd0);
    word_req = 0;
    cpu_a0 = 1;
    @(negedge clk);
    chk(bus_a0 == 1'b1, "R10 idle after reset", {15'd0, bus_a0}, 16'd1);
    cpu_a0 = 0;
    @(negedge clk);
  endtask

  initial begin
    mem8[0] = 8'h00; mem8[1] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_word_pass();
    t_split_read(1'b0);   // R1 split on missing acknowledge
    t_split_write();
    t_split_read(1'b1);   // R9 extra start ignored
    t_forced();
    t_gate();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule